// File: doc/BRIEF.md
# Pump Dry-Run Retry Supervisor

This block gates a pump motor and watches a water-flow sensor fitted where the delivery pipe enters the tank. The level logic upstream raises a run request. The supervisor then switches the motor on and gives it a bounded window in which water must arrive. When flow is seen, the motor keeps running and a running indication is shown. When the window closes with no flow, the motor is stopped, left off for a rest interval, and then started again without any operator action.

A failure is typically an air lock or a dead pump. After a fixed number of consecutive failed starts, the supervisor stops retrying. It latches a motor-fault flag and enables an audible alarm output, which drives a tone generator outside this block. The fault stays latched until an operator pulses the manual clear input. Both intervals are parameters counted in clock cycles.

Top module: `pump_dryrun_supervisor`

## Requirements
- R1: After a synchronous active-low reset, motor_en, running, fault and alarm_en are all 0.
- R2: In idle with run_req high, motor_en rises on the next clock. The no-flow window counter advances only while the motor is on and waiting for flow, and it is held cleared otherwise.
- R3: If flow_ok is high in any cycle of the no-flow window, including its final cycle, the block goes to the running state on the next clock. In that state running is 1 and motor_en stays 1 for as long as flow_ok and run_req stay high.
- R4: If flow_ok stays low for DRY_CYCLES consecutive cycles while the motor waits for flow, motor_en goes to 0 on the following clock. A loss of flow in the running state starts a fresh window.
- R5: After a no-flow stop that is not the last allowed attempt, motor_en stays 0 for exactly PAUSE_CYCLES cycles and then returns to 1 automatically.
- R6: The MAX_TRIES-th consecutive failed start sets fault and alarm_en and keeps motor_en at 0. This latched state ignores run_req and flow_ok.
- R7: A high fault_clr returns the block to idle on the next clock. It clears the fault, the alarm and the attempt count, and it overrides any other event in the same cycle, including a window expiry.
- R8: A start that sees flow resets the consecutive-failure count to zero.
- R9: Outside the fault state, a low run_req returns the block to idle on the next clock, with the motor off and both timers and the attempt count cleared. A later request gets a full DRY_CYCLES window.
- R10: running is 1 only while the motor is on and flow has been confirmed. It is 0 while the block waits for flow, pauses, idles or is faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_req | input | 1 | Pump demand from the level logic |
| flow_ok | input | 1 | Flow sensor, 1 when water is entering the tank |
| fault_clr | input | 1 | Manual clear of the fault and the retry state |
| motor_en | output | 1 | Motor contactor enable |
| running | output | 1 | Motor running with flow confirmed |
| fault | output | 1 | Latched motor-fault flag |
| alarm_en | output | 1 | Enable for the external alarm sounder |

## Verification
Two functions can fall in one cycle. The first case is flow arriving in the very last cycle of the no-flow window. The bench drives flow_ok high exactly in that cycle, and the motor must then pass into running rather than pausing. The second case is the manual clear arriving in the same cycle as the expiry of the last allowed attempt. The bench asserts fault_clr exactly then, and the block must show idle with no fault on the next cycle. Both outcomes are compared cycle by cycle against a behavioural model and also checked explicitly.

// File: rtl/psv_pkg.sv
// Shared types for the pump dry-run retry supervisor.
// Assumes: one state register in the top module uses this encoding.
package psv_pkg;

    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,  // motor off, no demand
        PS_PRIME = 3'd1,  // motor on, waiting for flow
        PS_RUN   = 3'd2,  // motor on, flow confirmed
        PS_PAUSE = 3'd3,  // motor off between attempts
        PS_FAULT = 3'd4   // latched failure, alarm on
    } psv_state_e;

endpackage

// File: rtl/psv_timer.sv
// Up-counter for the no-flow window and the rest interval.
// Counts one per clock unless cleared and saturates at all ones.
// Assumes: the owner clears it on every state change.
module psv_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);

    // Advance the count, or clear it on reset or on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (count != {W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/psv_tries.sv
// Consecutive failed-start counter.
// Flags the attempt that would be the last one allowed.
// Assumes: inc pulses once per failed window, and clr wins over inc.
module psv_tries #(
    parameter int unsigned MAX_TRIES = 3,
    parameter int unsigned W         = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    logic [W-1:0] tries_q;

    // Hold the number of failed starts since the last success or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tries_q <= '0;
        end else if (inc) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    // The next failure is the final one.
    assign last = (tries_q == W'(MAX_TRIES - 1));

endmodule

// File: rtl/pump_dryrun_supervisor.sv
// Pump dry-run retry supervisor.
// Starts the motor on demand and requires flow within DRY_CYCLES.
// On no flow it stops the motor, rests for PAUSE_CYCLES and retries.
// After MAX_TRIES consecutive failures it latches fault and alarm.
// Assumes: run_req, flow_ok and fault_clr are already synchronised.
module pump_dryrun_supervisor #(
    parameter int unsigned DRY_CYCLES   = 1_875_000_000,
    parameter int unsigned PAUSE_CYCLES = 1_250_000_000,
    parameter int unsigned MAX_TRIES    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic flow_ok,
    input  logic fault_clr,
    output logic motor_en,
    output logic running,
    output logic fault,
    output logic alarm_en
);
    import psv_pkg::*;

    localparam int unsigned LONGEST = (DRY_CYCLES > PAUSE_CYCLES) ? DRY_CYCLES : PAUSE_CYCLES;
    localparam int unsigned TW      = $clog2(LONGEST + 1);
    localparam int unsigned NW      = $clog2(MAX_TRIES + 1);

    psv_state_e    st_q, st_d;
    logic [TW-1:0] tmr;
    logic          tmr_clr;
    logic          tries_clr, tries_inc, tries_last;
    logic          dry_expired, pause_expired;

    // Terminal counts for the two intervals.
    assign dry_expired   = (st_q == PS_PRIME) && (tmr == TW'(DRY_CYCLES - 1));
    assign pause_expired = (st_q == PS_PAUSE) && (tmr == TW'(PAUSE_CYCLES - 1));

    // Next-state logic: clear, then fault hold, then demand, then the sequence.
    always_comb begin
        st_d      = st_q;
        tries_clr = 1'b0;
        tries_inc = 1'b0;
        if (fault_clr) begin
            st_d      = PS_IDLE;
            tries_clr = 1'b1;
        end else if (st_q == PS_FAULT) begin
            st_d = PS_FAULT;
        end else if (!run_req) begin
            st_d      = PS_IDLE;
            tries_clr = 1'b1;
        end else begin
            case (st_q)
                PS_IDLE:  st_d = PS_PRIME;
                PS_PRIME: begin
                    if (flow_ok) begin
                        st_d      = PS_RUN;
                        tries_clr = 1'b1;
                    end else if (dry_expired) begin
                        tries_inc = 1'b1;
                        st_d      = tries_last ? PS_FAULT : PS_PAUSE;
                    end
                end
                PS_RUN:   if (!flow_ok) st_d = PS_PRIME;
                PS_PAUSE: if (pause_expired) st_d = PS_PRIME;
                default:  st_d = PS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // The timer restarts on every transition and rests outside the timed states.
    assign tmr_clr = (st_d != st_q) || !((st_q == PS_PRIME) || (st_q == PS_PAUSE));

    psv_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .count (tmr)
    );

    psv_tries #(.MAX_TRIES(MAX_TRIES), .W(NW)) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tries_clr),
        .inc   (tries_inc),
        .last  (tries_last)
    );

    // Output decode from the registered state.
    assign motor_en = (st_q == PS_PRIME) || (st_q == PS_RUN);
    assign running  = (st_q == PS_RUN);
    assign fault    = (st_q == PS_FAULT);
    assign alarm_en = (st_q == PS_FAULT);

endmodule

// File: rtl/pump_dryrun_supervisor_chk.sv
// Port-level property checker for the pump dry-run retry supervisor.
// Assumes: it is bound into every instance of the top module.
module pump_dryrun_supervisor_chk #(
    parameter int unsigned DRY_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic run_req,
    input logic flow_ok,
    input logic fault_clr,
    input logic motor_en,
    input logic running,
    input logic fault,
    input logic alarm_en
);

    logic [31:0] dry_run_cnt;

    // Count consecutive cycles in which the motor runs without confirmed flow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dry_run_cnt <= '0;
        end else if (motor_en && !running) begin
            dry_run_cnt <= dry_run_cnt + 1;
        end else begin
            dry_run_cnt <= '0;
        end
    end

    p_dry_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_en && !running) |-> (dry_run_cnt < DRY_CYCLES));

    p_flow_confirms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_en && !running && flow_ok && run_req && !fault_clr) |=> running);

    p_fault_gates_motor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!motor_en && alarm_en));

    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);

    p_fault_after_attempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> ($past(motor_en) && !$past(running)));

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr |=> (!fault && !alarm_en && !motor_en));

    p_withdraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_req |=> (!motor_en && !running));

    p_running_needs_motor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> motor_en);

endmodule

bind pump_dryrun_supervisor pump_dryrun_supervisor_chk #(.DRY_CYCLES(DRY_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req   (run_req),
    .flow_ok   (flow_ok),
    .fault_clr (fault_clr),
    .motor_en  (motor_en),
    .running   (running),
    .fault     (fault),
    .alarm_en  (alarm_en)
);

// File: tb/pump_dryrun_supervisor_tb.sv
// Bench for the pump dry-run retry supervisor. A behavioural model is
// compared on every clock, and scenario checks cover each requirement.
module pump_dryrun_supervisor_tb;

    localparam int DRY   = 6;
    localparam int PAUSE = 4;
    localparam int TRIES = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0, flow_ok = 1'b0, fault_clr = 1'b0;
    logic motor_en, running, fault, alarm_en;

    int errors = 0;
    int checks = 0;
    bit chk_on = 0;
    bit done   = 0;
    string cur_req = "R1";

    // Model state: 0 idle, 1 waiting for flow, 2 running, 3 pause, 4 fault.
    int m_st = 0, m_t = 0, m_n = 0;

    always #4 clk = ~clk;

    pump_dryrun_supervisor #(
        .DRY_CYCLES(DRY), .PAUSE_CYCLES(PAUSE), .MAX_TRIES(TRIES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .flow_ok(flow_ok),
        .fault_clr(fault_clr), .motor_en(motor_en), .running(running),
        .fault(fault), .alarm_en(alarm_en)
    );

    task automatic model_next();
        if (!rst_n || fault_clr) begin
            m_st = 0; m_t = 0; m_n = 0;
        end else if (m_st == 4) begin
            m_st = 4;
        end else if (!run_req) begin
            m_st = 0; m_t = 0; m_n = 0;
        end else if (m_st == 0) begin
            m_st = 1; m_t = 0;
        end else if (m_st == 1) begin
            if (flow_ok) begin
                m_st = 2; m_n = 0; m_t = 0;
            end else if (m_t == DRY - 1) begin
                m_n++;
                m_st = (m_n == TRIES) ? 4 : 3;
                m_t = 0;
            end else begin
                m_t++;
            end
        end else if (m_st == 2) begin
            if (!flow_ok) begin m_st = 1; m_t = 0; end
        end else begin
            if (m_t == PAUSE - 1) begin m_st = 1; m_t = 0; end
            else m_t++;
        end
    endtask

    task automatic compare();
        logic em, er, ef;
        em = (m_st == 1) || (m_st == 2);
        er = (m_st == 2);
        ef = (m_st == 4);
        checks++;
        if (motor_en !== em || running !== er || fault !== ef || alarm_en !== ef) begin
            errors++;
            $display("FAIL %s: motor_en/running/fault/alarm_en = %b%b%b%b expected %b%b%b%b",
                     cur_req, motor_en, running, fault, alarm_en, em, er, ef, ef);
        end
    endtask

    task automatic expect_bit(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s = %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic expect_int(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s = %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: observe at the falling edge, then drive and advance the model.
    task automatic step(logic r, logic f, logic c);
        @(negedge clk);
        if (chk_on) compare();
        run_req = r; flow_ok = f; fault_clr = c;
        model_next();
    endtask

    task automatic hold(int n, logic r, logic f, logic c);
        for (int i = 0; i < n; i++) step(r, f, c);
    endtask

    // Count consecutive observations with motor_en == want and no flow confirmation.
    task automatic count_motor(logic want, logic r, logic f, output int n);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            step(r, f, 1'b0);
            if (motor_en === want && running === 1'b0 && fault === 1'b0) n++;
            else break;
        end
    endtask

    initial begin
        int n;
        int p;
        rst_n = 1'b0;
        hold(3, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_next();
        chk_on = 1;

        cur_req = "R1";
        step(0, 0, 0);
        expect_bit("R1", motor_en, 1'b0, "motor_en after reset");
        expect_bit("R1", running,  1'b0, "running after reset");
        expect_bit("R1", fault,    1'b0, "fault after reset");
        expect_bit("R1", alarm_en, 1'b0, "alarm_en after reset");

        cur_req = "R2";
        step(1, 0, 0);
        step(1, 0, 0);
        expect_bit("R2", motor_en, 1'b1, "motor_en one clock after demand");
        expect_bit("R10", running, 1'b0, "running while waiting for flow");

        cur_req = "R3";
        hold(2, 1, 0, 0);
        step(1, 1, 0);
        step(1, 1, 0);
        expect_bit("R3", running, 1'b1, "running after flow");
        hold(8, 1, 1, 0);
        expect_bit("R3", motor_en, 1'b1, "motor_en with steady flow");

        cur_req = "R4";
        step(1, 0, 0);
        count_motor(1'b1, 1, 0, n);
        expect_int("R4", n, DRY, "motor-on cycles without flow");
        cur_req = "R5";
        count_motor(1'b0, 1, 0, p);
        expect_int("R5", p + 1, PAUSE, "rest cycles before retry");
        expect_bit("R5", motor_en, 1'b1, "motor_en after rest");

        cur_req = "R3";
        hold(DRY - 2, 1, 0, 0);
        step(1, 1, 0);
        step(1, 1, 0);
        expect_bit("R3", running, 1'b1, "flow in last window cycle");

        cur_req = "R8";
        step(1, 0, 0);
        count_motor(1'b1, 1, 0, n);
        count_motor(1'b0, 1, 0, n);
        count_motor(1'b1, 1, 0, n);
        expect_bit("R8", fault, 1'b0, "fault after two failures following a success");
        count_motor(1'b0, 1, 0, n);
        cur_req = "R6";
        count_motor(1'b1, 1, 0, n);
        expect_bit("R6", fault,    1'b1, "fault after third failure");
        expect_bit("R6", alarm_en, 1'b1, "alarm_en after third failure");
        expect_bit("R6", motor_en, 1'b0, "motor_en in fault");
        hold(3, 0, 1, 0);
        hold(3, 1, 1, 0);
        step(1, 0, 0);
        expect_bit("R6", fault,    1'b1, "fault kept with demand and flow changes");
        expect_bit("R6", motor_en, 1'b0, "motor_en kept off in fault");

        cur_req = "R7";
        step(0, 0, 1);
        step(0, 0, 0);
        expect_bit("R7", fault,    1'b0, "fault after clear");
        expect_bit("R7", alarm_en, 1'b0, "alarm_en after clear");

        step(1, 0, 0);
        count_motor(1'b1, 1, 0, n);
        count_motor(1'b0, 1, 0, n);
        count_motor(1'b1, 1, 0, n);
        count_motor(1'b0, 1, 0, n);
        hold(DRY - 2, 1, 0, 0);
        step(1, 0, 1);
        step(1, 0, 0);
        expect_bit("R7", fault,    1'b0, "fault when clear meets last expiry");
        expect_bit("R7", motor_en, 1'b0, "motor_en idle after clear");

        cur_req = "R9";
        count_motor(1'b1, 1, 0, n);
        hold(2, 1, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        expect_bit("R9", motor_en, 1'b0, "motor_en after demand withdrawn");
        step(1, 0, 0);
        count_motor(1'b1, 1, 0, n);
        expect_int("R9", n, DRY, "full window after new demand");
        count_motor(1'b0, 1, 0, n);
        count_motor(1'b1, 1, 0, n);
        expect_bit("R9", fault, 1'b0, "attempt count cleared by withdrawal");
        hold(4, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1;
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, cycles=%0d expected fewer", 200000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule